// File: doc/BRIEF.md
# Lockable Watchdog Timer

A watchdog peripheral with one 32-bit control register on a plain strobe bus. Software sets a timeout and an enable bit. It then writes a reload bit from time to time to show that it is alive. A one-cycle seconds tick drives the countdown. If the count runs out, the block pulses a system reset output for a fixed number of clock cycles. It also records which kind of reset occurred in one of two status flags, picked by a configuration input.

A lock bit can be set once. After that, the enable bit, the timeout field and the lock bit itself cannot be changed until the next reset. Reload still works while the lock is set. The reset pulse that the watchdog produces clears the control fields. The status flags are cleared only by the power-on reset input or by a write-one-to-clear, so they survive the reset that the watchdog causes.

Top module: `wdt_lock_top`

## Requirements
- R1: After power-on reset, the register reads 0x0000_0000 and `wdt_rst_o` is low.
- R2: Register layout:
  - Timeout field: bits [9:0].
  - Lock bit: bit 12.
  - Enable bit: bit 14.
  - Reload bit: bit 31, which always reads 0.
  - Status flags: bits 24 and 25.
  - All other bits read 0 and ignore writes.
  - `rdata_o` is 0 whenever `rd_en_i` is low.
- R3: When the enable bit goes from 0 to 1, the counter loads from the timeout field. `wdt_rst_o` then rises on tick number (field + 1) and not before.
- R4: While the enable bit is 0, ticks have no effect and no reset is produced.
- R5: Writing 1 to bit 31 reloads the counter from the timeout field. This works even while the lock bit is set.
- R6: Writing a new timeout to a running watchdog does not change the count in progress. The new value is used only at the next reload or enable.
- R7: Once bit 12 is 1, writes cannot change bits 12, 14 or [9:0]. Only a reset releases the lock.
- R8: On expiry, `wdt_rst_o` is high for exactly RST_CYCLES clock cycles. Lock, enable and timeout read 0 afterwards.
- R9: Status flags:
  - On expiry, bit 25 is set if `surv_i` is 1, and bit 24 is set if it is 0.
  - Writing 1 to a flag clears it.
  - The flags persist across the watchdog reset.
  - `rst_ni` clears the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| tick_i | input | 1 | One-cycle seconds tick |
| surv_i | input | 1 | Selects which status flag an expiry sets |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while `rd_en_i` is high |
| wdt_rst_o | output | 1 | Watchdog system reset pulse |

## Verification
Some properties are checked by assertions on every cycle:
- Reserved and reload bits always read as zero.
- While the lock bit is set, the protected fields stay frozen.
- The lock bit falls only together with a reset pulse.
- The control fields stay clear for as long as that pulse lasts.
- A pulse never exceeds its length and always comes with a status flag.
- A status flag only drops after a write with a 1 at its position.

The scenarios in the bench are the only way to show:
- the exact tick count to expiry;
- that a timeout written to a running counter is deferred;
- that reload is honoured under lock;
- which flag `surv_i` selects;
- that the flags survive until power-on reset.

// File: rtl/wdt_lock_pkg.sv
package wdt_lock_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned LOCK_B  = 12;
  localparam int unsigned EN_B    = 14;
  localparam int unsigned STS0_B  = 24;  // expiry, supervisory state lost
  localparam int unsigned STS1_B  = 25;  // expiry, supervisory state kept
  localparam int unsigned RELOAD_B = 31;
  localparam int unsigned N_STS   = 2;
endpackage

// File: rtl/wdt_ctl_regs.sv
module wdt_ctl_regs
  import wdt_lock_pkg::*;
#(
  parameter int unsigned TOV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [TOV_W-1:0] wr_tov_i,
  input  logic             wr_en_bit_i,
  input  logic             wr_lock_i,
  input  logic             wr_reload_i,
  input  logic [N_STS-1:0] wr_sts_clr_i,
  input  logic             expire_i,
  input  logic             rst_busy_i,
  input  logic             surv_i,
  output logic [TOV_W-1:0] tov_o,
  output logic             en_o,
  output logic             lock_o,
  output logic [N_STS-1:0] sts_o,
  output logic             reload_o
);
  logic sys_clr;
  assign sys_clr = expire_i | rst_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tov_o    <= '0;
      en_o     <= 1'b0;
      lock_o   <= 1'b0;
      reload_o <= 1'b0;
    end else begin
      reload_o <= wr_en_i & wr_reload_i;
      if (sys_clr) begin
        tov_o  <= '0;
        en_o   <= 1'b0;
        lock_o <= 1'b0;
      end else if (wr_en_i && !lock_o) begin
        tov_o  <= wr_tov_i;
        en_o   <= wr_en_bit_i;
        lock_o <= wr_lock_i;
      end
    end
  end

  // Sticky cause flags: only power-on reset or W1C clears; expiry wins.
  for (genvar i = 0; i < N_STS; i++) begin : g_sts
    logic sel;
    assign sel = (i == 1) ? surv_i : !surv_i;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         sts_o[i] <= 1'b0;
      else if (expire_i && sel)            sts_o[i] <= 1'b1;
      else if (wr_en_i && wr_sts_clr_i[i]) sts_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned TOV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             reload_i,
  input  logic [TOV_W-1:0] tov_i,
  output logic             expire_o
);
  logic [TOV_W-1:0] cnt_q;
  logic             en_prev_q;
  logic             load;

  assign load     = en_i & (reload_i | !en_prev_q);
  assign expire_o = en_i & tick_i & !load & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      en_prev_q <= 1'b0;
    end else begin
      en_prev_q <= en_i;
      if (load)
        cnt_q <= tov_i;
      else if (en_i && tick_i && cnt_q != '0)
        cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= CW'(RST_CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/wdt_lock_top.sv
module wdt_lock_top
  import wdt_lock_pkg::*;
#(
  parameter int unsigned TOV_W      = 10,
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              surv_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              wdt_rst_o
);
  logic [TOV_W-1:0] tov_q;
  logic             en_q, lock_q, reload_q, expire;
  logic [N_STS-1:0] sts_q;
  logic [DATA_W-1:0] reg_view;

  wdt_ctl_regs #(.TOV_W(TOV_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_tov_i     (wdata_i[TOV_W-1:0]),
    .wr_en_bit_i  (wdata_i[EN_B]),
    .wr_lock_i    (wdata_i[LOCK_B]),
    .wr_reload_i  (wdata_i[RELOAD_B]),
    .wr_sts_clr_i (wdata_i[STS1_B:STS0_B]),
    .expire_i     (expire),
    .rst_busy_i   (wdt_rst_o),
    .surv_i       (surv_i),
    .tov_o        (tov_q),
    .en_o         (en_q),
    .lock_o       (lock_q),
    .sts_o        (sts_q),
    .reload_o     (reload_q)
  );

  wdt_countdown #(.TOV_W(TOV_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .en_i     (en_q),
    .reload_i (reload_q),
    .tov_i    (tov_q),
    .expire_o (expire)
  );

  wdt_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (expire),
    .busy_o  (wdt_rst_o)
  );

  always_comb begin
    reg_view                 = '0;
    reg_view[TOV_W-1:0]      = tov_q;
    reg_view[LOCK_B]         = lock_q;
    reg_view[EN_B]           = en_q;
    reg_view[STS1_B:STS0_B]  = sts_q;
  end

  assign rdata_o = rd_en_i ? reg_view : '0;
endmodule

// File: rtl/wdt_lock_chk.sv
module wdt_lock_chk #(
  parameter int unsigned TOV_W      = 10,
  parameter int unsigned RST_CYCLES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             rd_en_i,
  input logic [31:0]      wdata_i,
  input logic [31:0]      rdata_o,
  input logic             wdt_rst_o,
  input logic [TOV_W-1:0] tov_q,
  input logic             en_q,
  input logic             lock_q,
  input logic [1:0]       sts_q
);
  localparam logic [31:0] RESV_MASK = ~(32'h0300_5000 | ((32'h1 << TOV_W) - 1));
  logic [7:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_cnt <= '0;
    else if (wdt_rst_o) hi_cnt <= hi_cnt + 1'b1;
    else                hi_cnt <= '0;
  end

  AST_RST_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_cnt <= 8'(RST_CYCLES)); // R8
  AST_CTL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> (!en_q && !lock_q && tov_q == '0)); // R8
  AST_STS_ON_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> (sts_q != 2'b00)); // R9
  AST_STS0_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sts_q[0]) |-> $past(wr_en_i && wdata_i[24])); // R9
  AST_STS1_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sts_q[1]) |-> $past(wr_en_i && wdata_i[25])); // R9
  AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && $past(lock_q)) |-> ($stable(tov_q) && $stable(en_q))); // R7
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lock_q) |-> wdt_rst_o); // R7
  AST_RESV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & RESV_MASK) == 32'h0); // R2
  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == 32'h0); // R2
endmodule

bind wdt_lock_top wdt_lock_chk #(.TOV_W(TOV_W), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .wdt_rst_o (wdt_rst_o),
  .tov_q     (tov_q),
  .en_q      (en_q),
  .lock_q    (lock_q),
  .sts_q     (sts_q)
);

// File: tb/tb_wdt_lock_top.sv
module tb_wdt_lock_top;
  localparam int RST_CYCLES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, surv = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdt_rst;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  wdt_lock_top #(.TOV_W(10), .RST_CYCLES(RST_CYCLES)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .surv_i(surv),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
    .rdata_o(rdata), .wdt_rst_o(wdt_rst)
  );

  // Monitor: pops expected read data while a read strobe is active.
  always @(negedge clk) begin
    if (rd_en && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string t);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", t, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(posedge clk); #1 wr_en = 1'b1; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [31:0] e, input string t);
    @(posedge clk); #1 rd_en = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic pulse_tick();
    @(posedge clk); #1 tick = 1'b1;
    @(posedge clk); #1 tick = 1'b0;
  endtask

  task automatic ticks_quiet(input int n, input string t);
    for (int i = 0; i < n; i++) begin
      pulse_tick();
      chk(wdt_rst, 1'b0, t);
    end
  endtask

  // Measure the reset pulse; called right after the expiring tick.
  task automatic pulse_len(input string t);
    int n;
    n = 0;
    for (int i = 0; i < 20 && wdt_rst; i++) begin
      n++;
      @(posedge clk); #1;
    end
    total++;
    if (n != RST_CYCLES) begin
      bad++;
      $display("FAIL %s: pulse length actual=%0d expected=%0d", t, n, RST_CYCLES);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(wdt_rst, 1'b0, "R1 reset output");
    rd(32'h0, "R1 reset value");

    // R2 layout, reserved bits and reload bit read 0
    wr(32'h0000_A3FF);
    rd(32'h0000_03FF, "R2 reserved ignored");
    wr(32'h8000_0155);
    rd(32'h0000_0155, "R2 reload reads 0");

    // R3 expiry after field+1 ticks
    wr(32'h0000_4002);
    rd(32'h0000_4002, "R2 enable readback");
    ticks_quiet(2, "R3 early");
    pulse_tick();
    chk(wdt_rst, 1'b1, "R3 expiry");
    pulse_len("R8 pulse length");
    rd(32'h0100_0000, "R8 R9 cleared ctl, flag24");
    wr(32'h0100_0000);
    rd(32'h0, "R9 w1c");

    // R4 disabled ignores ticks; re-enable loads
    wr(32'h0000_4001);
    wr(32'h0000_0001);
    ticks_quiet(5, "R4 disabled");
    wr(32'h0000_4001);
    ticks_quiet(1, "R3 reenable");
    pulse_tick();
    chk(wdt_rst, 1'b1, "R3 reenable expiry");
    pulse_len("R8 pulse length 2");
    wr(32'h0100_0000);

    // R5 keepalive
    wr(32'h0000_4002);
    ticks_quiet(2, "R5 before reload");
    wr(32'h8000_4002);
    rd(32'h0000_4002, "R5 reload readback");
    ticks_quiet(2, "R5 after reload");
    pulse_tick();
    chk(wdt_rst, 1'b1, "R5 expiry after reload");
    pulse_len("R8 pulse length 3");
    wr(32'h0100_0000);

    // R6 new timeout deferred
    wr(32'h0000_4001);
    wr(32'h0000_4005);
    rd(32'h0000_4005, "R6 field updated");
    ticks_quiet(1, "R6 old count");
    pulse_tick();
    chk(wdt_rst, 1'b1, "R6 old timeout used");
    pulse_len("R8 pulse length 4");
    wr(32'h0100_0000);

    // R7 lock, with reload honoured under lock
    wr(32'h0000_5003);
    rd(32'h0000_5003, "R7 locked");
    wr(32'h0000_0000);
    rd(32'h0000_5003, "R7 clear blocked");
    wr(32'h0000_4001);
    rd(32'h0000_5003, "R7 field blocked");
    ticks_quiet(3, "R7 count");
    wr(32'h8000_0000);
    ticks_quiet(3, "R5 reload under lock");
    pulse_tick();
    chk(wdt_rst, 1'b1, "R5 locked expiry");
    pulse_len("R8 pulse length 5");
    rd(32'h0100_0000, "R8 lock cleared");
    wr(32'h0100_0007);
    rd(32'h0000_0007, "R7 unlocked after reset");

    // R9 flag selection, persistence
    surv = 1'b1;
    wr(32'h0000_4000);
    pulse_tick();
    chk(wdt_rst, 1'b1, "R9 surv expiry");
    pulse_len("R8 pulse length 6");
    rd(32'h0200_0000, "R9 flag25");
    wr(32'h0100_0000);
    rd(32'h0200_0000, "R9 other flag kept");
    surv = 1'b0;
    wr(32'h0000_4000);
    pulse_tick();
    chk(wdt_rst, 1'b1, "R9 second expiry");
    pulse_len("R8 pulse length 7");
    rd(32'h0300_0000, "R9 both flags");

    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    rd(32'h0, "R9 power-on clears flags");

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      bad++; total++;
      $display("FAIL scoreboard: pending actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule